// File: doc/BRIEF.md
# Lockstep Lag Controller with Random Wait States

This block sits beside a pair of redundant cores that run the same program, one ahead of the other. It counts how far the trailing core is behind by watching both cores' instruction commit strobes, and it drives a separate stall line to each core. The two stall lines keep the lag inside a window. The lower edge keeps the trailing core strictly behind the leading one. The upper edge keeps the comparison buffer between the cores from overflowing.

Inside the window, the block can also add wait states to either core on its own. Each core has its own 16-bit pseudo-random sequence. When that sequence's low byte falls below a rate value set by software, the core gets an extra stall cycle. Because each core is stalled independently, the delay between the cores wanders instead of staying fixed. For example, rates near 6% and 18% of cycles correspond to rate values of about 16 and 46.

Software sets the window edges, the two rates and the two enables through a small write-only register port.

Top module: `lagstep_top`

## Requirements
- R1: While reset is held and in the first cycle after release, the lag count is 0, the trailing core is stalled, the leading core is not stalled, and the registers hold their defaults: lower edge 3, upper edge 7, rates 0, enables off.
- R2: The lag count rises by one on a cycle with only a leading commit. It falls by one on a cycle with only a trailing commit. It is unchanged when both cores commit or neither does.
- R3: The trailing core is force-stalled when the lag is 0, or when the lag is at or below the lower edge and below the buffer depth (16 by default).
- R4: The leading core is force-stalled when the lag equals the buffer depth, or when the lag is at or above the upper edge, unless the trailing core is force-stalled.
- R5: The capacity limits take priority over the window edges. At a lag equal to the buffer depth, the trailing core is free even if the lower edge is larger. At a lag of 0, the leading core is free even if the upper edge is 0.
- R6: Each core has a 16-bit Galois sequence that shifts right every cycle after reset. When the bit shifted out is 1, the shifted value is XORed with 0xB400. The leading core's sequence is seeded with 0xACE1 and the trailing core's with 0x1D2B. A core gets a random stall in a cycle when its enable is set and its sequence's low byte, before that cycle's shift, is less than its 8-bit rate.
- R7: No random stall reaches either core in a cycle where either core is force-stalled.
- R8: With a core's enable clear, that core gets no random stall whatever its rate. With a rate of 0, that core gets no random stall whatever its enable.
- R9: A register write, taken on a clock edge with the write strobe high, uses the select values 0 (lower edge), 1 (upper edge), 2 (leading rate), 3 (trailing rate) and 4 (enables: bit 0 for the leading core, bit 1 for the trailing core). A write takes effect from the next cycle. Writes with select values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| leadCommit | input | 1 | Leading core retired an instruction this cycle |
| trailCommit | input | 1 | Trailing core retired an instruction this cycle |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select |
| cfgData | input | 8 | Register write data |
| leadStall | output | 1 | Stall to the leading core |
| trailStall | output | 1 | Stall to the trailing core |
| lagCount | output | 5 | Current lag in committed instructions |

## Verification
The assertions assume that each core obeys its stall line: a core never commits in a cycle where its stall is high. From that assumption they conclude that the lag never goes below zero or above the buffer depth. The bench models both cores as obeying this rule. Each cycle it asserts a core's commit only when the core wants to commit and the stall the bench predicts for that core is low. So every commit pattern it applies, including the random ones used while the random wait states run, stays inside what the design expects.

// File: rtl/lagstep_pkg.sv
package lagstep_pkg;

  // Comparison results the datapath hands to the control
  typedef struct packed {
    logic lagEmpty;
    logic lagFull;
    logic atMin;
    logic atMax;
    logic leadRnd;
    logic trailRnd;
  } lagFlags_t;

  // Stall decisions the control hands back
  typedef struct packed {
    logic leadForce;
    logic trailForce;
    logic leadDummy;
    logic trailDummy;
  } stallStrobes_t;

  typedef enum logic [2:0] {
    CFG_MIN_LAG    = 3'd0,
    CFG_MAX_LAG    = 3'd1,
    CFG_LEAD_RATE  = 3'd2,
    CFG_TRAIL_RATE = 3'd3,
    CFG_ENABLES    = 3'd4
  } cfgSel_e;

endpackage

// File: rtl/lagstep_datapath.sv
module lagstep_datapath
  import lagstep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CFG_W = 8,
  parameter int RATE_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] LEAD_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TRAIL_SEED = 16'h1D2B,
  parameter int MIN_LAG_RST = 3,
  parameter int MAX_LAG_RST = 7,
  localparam int LAG_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             leadCommit,
  input  logic             trailCommit,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  output logic [LAG_W-1:0] lagCount,
  output lagFlags_t        flags
);

  localparam int NCORE = 2;
  localparam int CMP_W = (LAG_W > CFG_W) ? LAG_W : CFG_W;

  logic [LAG_W-1:0]              lagQ;
  logic [CFG_W-1:0]              minLagQ;
  logic [CFG_W-1:0]              maxLagQ;
  logic [NCORE-1:0][RATE_W-1:0]  rateQ;
  logic [NCORE-1:0]              enQ;
  logic [NCORE-1:0]              rnd;

  // Lag counter: one step per unmatched commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lagQ <= '0;
    end else begin
      case ({leadCommit, trailCommit})
        2'b10:   lagQ <= lagQ + 1'b1;
        2'b01:   lagQ <= lagQ - 1'b1;
        default: lagQ <= lagQ;
      endcase
    end
  end

  // Software registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      minLagQ <= CFG_W'(MIN_LAG_RST);
      maxLagQ <= CFG_W'(MAX_LAG_RST);
      rateQ   <= '0;
      enQ     <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        CFG_MIN_LAG:    minLagQ  <= cfgData;
        CFG_MAX_LAG:    maxLagQ  <= cfgData;
        CFG_LEAD_RATE:  rateQ[0] <= cfgData[RATE_W-1:0];
        CFG_TRAIL_RATE: rateQ[1] <= cfgData[RATE_W-1:0];
        CFG_ENABLES:    enQ      <= cfgData[NCORE-1:0];
        default:        ;
      endcase
    end
  end

  // One pseudo-random source per core
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam logic [LFSR_W-1:0] SEED = (c == 0) ? LEAD_SEED : TRAIL_SEED;
    logic [LFSR_W-1:0] lfsr;

    always_ff @(posedge clk) begin
      if (!rst_n) lfsr <= SEED;
      else        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_MASK : '0);
    end

    assign rnd[c] = enQ[c] && (lfsr[RATE_W-1:0] < rateQ[c]);

    // R6: a nonzero seed never collapses to the all-zero lock-up state
    a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);
  end

  logic [CMP_W-1:0] lagExt, minExt, maxExt;
  assign lagExt = CMP_W'(lagQ);
  assign minExt = CMP_W'(minLagQ);
  assign maxExt = CMP_W'(maxLagQ);

  always_comb begin
    flags.lagEmpty = (lagQ == '0);
    flags.lagFull  = (lagExt >= CMP_W'(DEPTH));
    flags.atMin    = (lagExt <= minExt);
    flags.atMax    = (lagExt >= maxExt);
    flags.leadRnd  = rnd[0];
    flags.trailRnd = rnd[1];
  end

  assign lagCount = lagQ;

  a_r2_lag_up: assert property (@(posedge clk) disable iff (!rst_n)
    (leadCommit && !trailCommit) |=> (lagQ == $past(lagQ) + 1'b1));

  a_r2_lag_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!leadCommit && trailCommit) |=> (lagQ == $past(lagQ) - 1'b1));

  a_r4_lag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lagQ <= LAG_W'(DEPTH));

endmodule

// File: rtl/lagstep_control.sv
module lagstep_control
  import lagstep_pkg::*;
(
  input  lagFlags_t     flags,
  output stallStrobes_t strobes
);

  logic anyForce;

  always_comb begin
    // Capacity bounds first, then the programmed window (R3, R4, R5)
    strobes.trailForce = flags.lagEmpty || (!flags.lagFull && flags.atMin);
    strobes.leadForce  = !strobes.trailForce && (flags.lagFull || flags.atMax);
    anyForce           = strobes.leadForce || strobes.trailForce;
    // Random wait states only when no mandatory stall is active (R7)
    strobes.leadDummy  = flags.leadRnd  && !anyForce;
    strobes.trailDummy = flags.trailRnd && !anyForce;
  end

endmodule

// File: rtl/lagstep_top.sv
module lagstep_top
  import lagstep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CFG_W = 8,
  parameter int RATE_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] LEAD_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TRAIL_SEED = 16'h1D2B,
  parameter int MIN_LAG_RST = 3,
  parameter int MAX_LAG_RST = 7,
  localparam int LAG_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             leadCommit,
  input  logic             trailCommit,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  output logic             leadStall,
  output logic             trailStall,
  output logic [LAG_W-1:0] lagCount
);

  lagFlags_t     flags;
  stallStrobes_t strobes;

  lagstep_datapath #(
    .DEPTH(DEPTH), .CFG_W(CFG_W), .RATE_W(RATE_W), .LFSR_W(LFSR_W),
    .LFSR_MASK(LFSR_MASK), .LEAD_SEED(LEAD_SEED), .TRAIL_SEED(TRAIL_SEED),
    .MIN_LAG_RST(MIN_LAG_RST), .MAX_LAG_RST(MAX_LAG_RST)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n),
    .leadCommit(leadCommit), .trailCommit(trailCommit),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .lagCount(lagCount), .flags(flags)
  );

  lagstep_control u_control (
    .flags(flags),
    .strobes(strobes)
  );

  assign leadStall  = strobes.leadForce  | strobes.leadDummy;
  assign trailStall = strobes.trailForce | strobes.trailDummy;

  // R3/R4: the cores are expected to hold their commits while stalled
  a_r3_trail_commit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    trailStall |-> !trailCommit);

  a_r4_lead_commit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    leadStall |-> !leadCommit);

  a_r5_empty_lead_free: assert property (@(posedge clk) disable iff (!rst_n)
    (lagCount == '0) |-> (trailStall && !leadStall));

  a_r5_full_trail_free: assert property (@(posedge clk) disable iff (!rst_n)
    (lagCount == LAG_W'(DEPTH)) |-> (leadStall && !trailStall));

endmodule

// File: tb/lagstep_top_bench.sv
module lagstep_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       leadCommit, trailCommit, cfgWe;
  logic [2:0] cfgSel;
  logic [7:0] cfgData;
  logic       leadStall, trailStall;
  logic [4:0] lagCount;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Requirement model state
  int         mLag;
  int         mMin, mMax;
  int         mRate [2];
  bit         mEn [2];
  logic [15:0] mLfsr [2];
  int unsigned rs = 32'h2545F491;

  always #(CLK_PERIOD/2) clk = ~clk;

  lagstep_top u_lagstep_top (
    .clk(clk), .rst_n(rst_n),
    .leadCommit(leadCommit), .trailCommit(trailCommit),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .leadStall(leadStall), .trailStall(trailStall), .lagCount(lagCount)
  );

  function automatic bit rbit();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[3];
  endfunction

  function automatic logic [15:0] lfsrStep(logic [15:0] v);
    return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
  endfunction

  task automatic expectStalls(output bit eL, output bit eT);
    bit empty, full, atMin, atMax, tF, lF, r0, r1;
    empty = (mLag == 0);
    full  = (mLag >= DEPTH);
    atMin = (mLag <= mMin);
    atMax = (mLag >= mMax);
    tF = empty || (!full && atMin);
    lF = !tF && (full || atMax);
    r0 = mEn[0] && (int'(mLfsr[0][7:0]) < mRate[0]);
    r1 = mEn[1] && (int'(mLfsr[1][7:0]) < mRate[1]);
    eL = lF || (r0 && !(tF || lF));
    eT = tF || (r1 && !(tF || lF));
  endtask

  task automatic compare(input string tag);
    bit eL, eT;
    expectStalls(eL, eT);
    checks++;
    if (leadStall !== eL || trailStall !== eT || int'(lagCount) != mLag) begin
      fails++;
      $display("FAIL %s: lead=%0b trail=%0b lag=%0d expected lead=%0b trail=%0b lag=%0d",
               tag, leadStall, trailStall, lagCount, eL, eT, mLag);
    end
  endtask

  // One cycle, called at a falling edge
  task automatic cyc(input bit wantL, input bit wantT, input bit we,
                     input logic [2:0] sel, input logic [7:0] data, input string tag);
    bit eL, eT, lc, tc;
    compare(tag);
    expectStalls(eL, eT);
    lc = wantL && !eL;
    tc = wantT && !eT;
    leadCommit = lc; trailCommit = tc;
    cfgWe = we; cfgSel = sel; cfgData = data;
    @(posedge clk);
    mLag = mLag + int'(lc) - int'(tc);
    if (we) begin
      case (sel)
        3'd0: mMin = int'(data);
        3'd1: mMax = int'(data);
        3'd2: mRate[0] = int'(data);
        3'd3: mRate[1] = int'(data);
        3'd4: begin mEn[0] = data[0]; mEn[1] = data[1]; end
        default: ;
      endcase
    end
    mLfsr[0] = lfsrStep(mLfsr[0]);
    mLfsr[1] = lfsrStep(mLfsr[1]);
    @(negedge clk);
    leadCommit = 0; trailCommit = 0; cfgWe = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data, input string tag);
    cyc(0, 0, 1, sel, data, tag);
  endtask

  task automatic t_reset();
    rst_n = 0; leadCommit = 0; trailCommit = 0; cfgWe = 0; cfgSel = 0; cfgData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset held");
    rst_n = 1;
    mLag = 0; mMin = 3; mMax = 7; mRate[0] = 0; mRate[1] = 0;
    mEn[0] = 0; mEn[1] = 0; mLfsr[0] = 16'hACE1; mLfsr[1] = 16'h1D2B;
    compare("R1 after release");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 0, "R4 fill to upper edge");
    for (int i = 0; i < 4; i++)  cyc(1, 1, 0, 0, 0, "R2 matched commits");
  endtask

  task automatic t_drain();
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, "R3 drain to lower edge");
    for (int i = 0; i < 6; i++)  cyc(1, 1, 0, 0, 0, "R2 both commit");
  endtask

  task automatic t_capacity();
    wr(3'd1, 8'd255, "R9 write upper edge");
    wr(3'd0, 8'd255, "R9 write lower edge");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, "R5 fill to capacity");
    for (int i = 0; i < 3; i++)  cyc(0, 1, 0, 0, 0, "R5 trail free at capacity");
    wr(3'd0, 8'd0, "R9 lower edge zero");
    wr(3'd1, 8'd0, "R9 upper edge zero");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 0, "R5 drain to empty");
    cyc(1, 0, 0, 0, 0, "R5 lead free at empty");
    cyc(1, 1, 0, 0, 0, "R4 upper edge zero");
    wr(3'd0, 8'd3, "R9 restore lower");
    wr(3'd1, 8'd7, "R9 restore upper");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R2 refill");
  endtask

  task automatic t_gated();
    wr(3'd2, 8'd200, "R9 lead rate");
    wr(3'd3, 8'd200, "R9 trail rate");
    for (int i = 0; i < 40; i++) cyc(rbit(), rbit(), 0, 0, 0, "R8 enables off");
    wr(3'd2, 8'd0, "R9 lead rate zero");
    wr(3'd3, 8'd0, "R9 trail rate zero");
    wr(3'd4, 8'd3, "R9 enables on");
    for (int i = 0; i < 40; i++) cyc(rbit(), rbit(), 0, 0, 0, "R8 rate zero");
  endtask

  task automatic t_dummy();
    wr(3'd2, 8'd46, "R9 lead rate 18pct");
    wr(3'd3, 8'd16, "R9 trail rate 6pct");
    for (int i = 0; i < 300; i++) cyc(1, 1, 0, 0, 0, "R6 random wait states");
    wr(3'd4, 8'd1, "R9 lead enable only");
    for (int i = 0; i < 100; i++) cyc(rbit(), 1, 0, 0, 0, "R6 lead only");
  endtask

  task automatic t_yield();
    wr(3'd4, 8'd3, "R9 enables on");
    wr(3'd2, 8'd255, "R9 lead rate max");
    wr(3'd3, 8'd255, "R9 trail rate max");
    for (int i = 0; i < 200; i++) cyc(rbit() | rbit(), rbit(), 0, 0, 0, "R7 forced beats random");
  endtask

  task automatic t_badsel();
    wr(3'd4, 8'd0, "R9 enables off");
    for (int s = 5; s < 8; s++) wr(3'(s), 8'hFF, "R9 unused select");
    for (int i = 0; i < 30; i++) cyc(1, rbit(), 0, 0, 0, "R9 unused select no effect");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_drain();
    t_capacity();
    t_gated();
    t_dummy();
    t_yield();
    t_badsel();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule